// File: doc/BRIEF.md
# Eight-bit ALU with flags

A purely combinational arithmetic and logic unit for a small eight-bit processor datapath. Given two operands, a 3-bit function code, a 2-bit carry-mode field and the stored carry flag, it returns a result together with sign, zero, overflow, carry and auxiliary-carry flags. A separate shift request, with its own direction bit, turns the unit into a one-bit shifter of operand A.

Around the unit, a register file supplies the operands and a flag register captures the flags when `flag_we` is high. A compare request produces the same result and flags as the function selected, but raises `result_discard` so that the surrounding datapath writes no register.

Top module: `alu8_core`

## Requirements
- R1: Function codes on `func_sel`: 0 gives 0x00, 4 gives A xor B, 5 gives A or B, 6 gives A and B, 7 gives 0xFF. For these codes the carry, overflow and auxiliary flags are 0.
- R2: Code 3 adds A+B. Carry is the carry out of bit 7, auxiliary carry is the carry out of bit 3, and overflow follows two's-complement rules. With `carry_mode` 0, 1 or 2, `carry_in` has no effect.
- R3: With `carry_mode` 3 (binary 11), code 3 adds `carry_in` as well: A+B+carry_in.
- R4: Code 2 computes A−B and code 1 computes B−A. Carry is the borrow out of bit 7 (the minuend was below the subtrahend plus borrow), auxiliary carry is the borrow out of bit 3, and overflow follows two's-complement rules. `carry_in` has no effect on code 1 in any mode, and none on code 2 in modes 0 to 2.
- R5: With `carry_mode` 3, code 2 subtracts with borrow: A−B−carry_in.
- R6: `flag_sign` equals result bit 7. `flag_zero` is 1 exactly when the result is 0x00.
- R7: With `shift_en`=1 the function code is ignored and operand A is shifted by one bit: left when `shift_right`=0, right when it is 1. A zero fills the vacated bit, the bit shifted out goes to carry, and overflow and auxiliary carry are 0.
- R8: `flag_we` is 0 for codes 0 and 7 when no shift is requested, and 1 for every other operation.
- R9: `cmp_req`=1 sets `result_discard`=1 and leaves the result and all flags as they would be without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | Operand A, also the shift source |
| opnd_b | input | 8 | Operand B |
| func_sel | input | 3 | Function code |
| carry_mode | input | 2 | Carry-mode field; 3 folds in `carry_in` |
| shift_en | input | 1 | Selects a one-bit shift of A |
| shift_right | input | 1 | Shift direction: 0 left, 1 right |
| carry_in | input | 1 | Stored carry flag |
| cmp_req | input | 1 | Compare: compute flags, discard result |
| result | output | 8 | Result |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Two's-complement overflow |
| flag_carry | output | 1 | Carry, borrow or shifted-out bit |
| flag_aux | output | 1 | Carry or borrow out of bit 3 |
| flag_we | output | 1 | Flag write enable |
| result_discard | output | 1 | Result must not be written |

## Verification
Every output is a combinational function of the current inputs, so each result and flag is due in the cycle in which its inputs are applied, with zero cycles of latency. The driver changes the inputs just after a rising edge and queues the expected values. The monitor pops one item at the next falling edge, half a period later, so every comparison sees settled outputs for exactly the stimulus it was queued with.

// File: rtl/alu8_pkg.sv
// Package: shared types for the eight-bit ALU.
// Assumes: function codes are the 3-bit values listed in the brief.
package alu8_pkg;

    typedef enum logic [2:0] {
        FN_ZERO  = 3'd0,
        FN_BSUBA = 3'd1,
        FN_ASUBB = 3'd2,
        FN_ADD   = 3'd3,
        FN_XOR   = 3'd4,
        FN_OR    = 3'd5,
        FN_AND   = 3'd6,
        FN_ONES  = 3'd7
    } alu_func_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic ovf;
        logic carry;
        logic aux;
    } alu_flags_t;

    localparam logic [1:0] CARRY_MODE_USE = 2'b11;

endpackage

// File: rtl/alu8_arith.sv
// Module: shared ripple adder for add, add-with-carry and both subtractions.
// Assumes: the caller orders the operands (x is the minuend) and passes the
// effective carry or borrow in; for subtraction y is inverted here.
module alu8_arith #(
    parameter int WIDTH   = 8,
    parameter int AUX_BIT = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             is_sub,
    input  logic             cb_in,
    output logic [WIDTH-1:0] sum,
    output alu8_pkg::alu_flags_t flags
);
    logic [WIDTH-1:0] y_eff;
    logic [WIDTH:0]   chain;

    // Operand conditioning: subtraction adds the inverted subtrahend plus one minus borrow.
    always_comb begin
        y_eff    = is_sub ? ~y : y;
        chain[0] = is_sub ? ~cb_in : cb_in;
    end

    // One full adder per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            sum[i]      = x[i] ^ y_eff[i] ^ chain[i];
            chain[i+1]  = (x[i] & y_eff[i]) | (chain[i] & (x[i] ^ y_eff[i]));
        end
    end

    // Flag derivation: borrow is the inverse of carry for subtraction.
    always_comb begin
        flags.sign  = sum[WIDTH-1];
        flags.zero  = (sum == '0);
        flags.ovf   = chain[WIDTH] ^ chain[WIDTH-1];
        flags.carry = chain[WIDTH] ^ is_sub;
        flags.aux   = chain[AUX_BIT] ^ is_sub;
    end

endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise functions and the two constants.
// Assumes: only codes 0, 4, 5, 6 and 7 are routed here; other codes give 0.
module alu8_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       func,
    output logic [WIDTH-1:0] res,
    output alu8_pkg::alu_flags_t flags
);
    import alu8_pkg::*;

    // Function decode for the non-arithmetic codes.
    always_comb begin
        unique case (alu_func_e'(func))
            FN_XOR:  res = a ^ b;
            FN_OR:   res = a | b;
            FN_AND:  res = a & b;
            FN_ONES: res = '1;
            default: res = '0;
        endcase
    end

    // Flags: only sign and zero carry information here.
    always_comb begin
        flags.sign  = res[WIDTH-1];
        flags.zero  = (res == '0);
        flags.ovf   = 1'b0;
        flags.carry = 1'b0;
        flags.aux   = 1'b0;
    end

endmodule

// File: rtl/alu8_shift.sv
// Module: one-bit logical shift of operand A in either direction.
// Assumes: a zero enters the vacated bit; the bit leaving goes to carry.
module alu8_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             to_right,
    output logic [WIDTH-1:0] res,
    output alu8_pkg::alu_flags_t flags
);
    logic out_bit;

    // Shift datapath and the bit it drops.
    always_comb begin
        if (to_right) begin
            res     = {1'b0, a[WIDTH-1:1]};
            out_bit = a[0];
        end else begin
            res     = {a[WIDTH-2:0], 1'b0};
            out_bit = a[WIDTH-1];
        end
    end

    // Flags for a shift.
    always_comb begin
        flags.sign  = res[WIDTH-1];
        flags.zero  = (res == '0);
        flags.ovf   = 1'b0;
        flags.carry = out_bit;
        flags.aux   = 1'b0;
    end

endmodule

// File: rtl/alu8_core.sv
// Module: top of the eight-bit ALU. Steers operands into the shared adder,
// selects among adder, logic unit and shifter, and produces the flag write
// enable and the compare discard.
// Assumes: fully combinational; the flag register lives outside.
module alu8_core #(
    parameter int WIDTH   = 8,
    parameter int AUX_BIT = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       func_sel,
    input  logic [1:0]       carry_mode,
    input  logic             shift_en,
    input  logic             shift_right,
    input  logic             carry_in,
    input  logic             cmp_req,
    output logic [WIDTH-1:0] result,
    output logic             flag_sign,
    output logic             flag_zero,
    output logic             flag_ovf,
    output logic             flag_carry,
    output logic             flag_aux,
    output logic             flag_we,
    output logic             result_discard
);
    import alu8_pkg::*;

    alu_func_e        fn;
    logic             is_arith;
    logic             is_const;
    logic             ar_sub;
    logic             ar_cb;
    logic [WIDTH-1:0] ar_x;
    logic [WIDTH-1:0] ar_y;
    logic [WIDTH-1:0] ar_res;
    logic [WIDTH-1:0] lg_res;
    logic [WIDTH-1:0] sh_res;
    alu_flags_t       ar_flags;
    alu_flags_t       lg_flags;
    alu_flags_t       sh_flags;
    alu_flags_t       sel_flags;

    // Decode of the function code into unit selects.
    always_comb begin
        fn       = alu_func_e'(func_sel);
        is_arith = (fn == FN_BSUBA) || (fn == FN_ASUBB) || (fn == FN_ADD);
        is_const = (fn == FN_ZERO) || (fn == FN_ONES);
    end

    // Operand ordering and carry folding for the shared adder.
    always_comb begin
        ar_sub = (fn == FN_BSUBA) || (fn == FN_ASUBB);
        ar_x   = (fn == FN_BSUBA) ? opnd_b : opnd_a;
        ar_y   = (fn == FN_BSUBA) ? opnd_a : opnd_b;
        ar_cb  = (carry_mode == CARRY_MODE_USE) &&
                 ((fn == FN_ADD) || (fn == FN_ASUBB)) && carry_in;
    end

    alu8_arith #(.WIDTH(WIDTH), .AUX_BIT(AUX_BIT)) u_arith (
        .x      (ar_x),
        .y      (ar_y),
        .is_sub (ar_sub),
        .cb_in  (ar_cb),
        .sum    (ar_res),
        .flags  (ar_flags)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a     (opnd_a),
        .b     (opnd_b),
        .func  (func_sel),
        .res   (lg_res),
        .flags (lg_flags)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .a        (opnd_a),
        .to_right (shift_right),
        .res      (sh_res),
        .flags    (sh_flags)
    );

    // Output selection: shift overrides the function code.
    always_comb begin
        if (shift_en) begin
            result    = sh_res;
            sel_flags = sh_flags;
        end else if (is_arith) begin
            result    = ar_res;
            sel_flags = ar_flags;
        end else begin
            result    = lg_res;
            sel_flags = lg_flags;
        end
        flag_sign      = sel_flags.sign;
        flag_zero      = sel_flags.zero;
        flag_ovf       = sel_flags.ovf;
        flag_carry     = sel_flags.carry;
        flag_aux       = sel_flags.aux;
        flag_we        = shift_en || !is_const;
        result_discard = cmp_req;
    end

    // Output checks guarding the selection above.
    always_comb begin
        AST_LOGIC_FLAGS_CLR: assert (shift_en || is_arith ||
                                     (!flag_carry && !flag_ovf && !flag_aux))
            else $error("logic/constant left arithmetic flags set"); // R1
        AST_SIGN_FOLLOWS: assert (flag_sign == result[WIDTH-1])
            else $error("sign flag disagrees with result"); // R6
        AST_ZERO_FOLLOWS: assert (flag_zero == (result == '0))
            else $error("zero flag disagrees with result"); // R6
        AST_SHIFT_CARRY: assert (!shift_en ||
                                 (flag_carry == (shift_right ? opnd_a[0] : opnd_a[WIDTH-1])
                                  && !flag_ovf && !flag_aux))
            else $error("shift carry wrong"); // R7
        AST_SHIFT_FILL: assert (!shift_en ||
                                (shift_right ? !result[WIDTH-1] : !result[0]))
            else $error("shift fill bit not zero"); // R7
        AST_CONST_NO_WE: assert (shift_en || !is_const ||
                                 (!flag_we && ((result == '0) || (result == '1))))
            else $error("constant wrote flags or bad value"); // R8
    end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [2:0] func_sel = '0;
    logic [1:0] carry_mode = '0;
    logic       shift_en = 1'b0;
    logic       shift_right = 1'b0;
    logic       carry_in = 1'b0;
    logic       cmp_req = 1'b0;
    logic [7:0] result;
    logic       flag_sign, flag_zero, flag_ovf, flag_carry, flag_aux;
    logic       flag_we, result_discard;

    alu8_core dut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .func_sel(func_sel),
        .carry_mode(carry_mode), .shift_en(shift_en), .shift_right(shift_right),
        .carry_in(carry_in), .cmp_req(cmp_req), .result(result),
        .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
        .flag_carry(flag_carry), .flag_aux(flag_aux), .flag_we(flag_we),
        .result_discard(result_discard)
    );

    typedef struct {
        string      tag;
        logic [7:0] res;
        logic [6:0] fl;   // sign, zero, ovf, carry, aux, we, discard
    } exp_t;

    exp_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    function automatic int sx(input logic [7:0] v);
        return v[7] ? int'(v) - 256 : int'(v);
    endfunction

    // Reference model built from the requirements.
    function automatic exp_t model(input string tag, input logic [7:0] a, input logic [7:0] b,
                                   input logic [2:0] f, input logic [1:0] cm, input logic sh,
                                   input logic dir, input logic ci, input logic cmp);
        exp_t e;
        int full, nib, sv, k;
        logic [7:0] x, y, r;
        logic v, c, ac, we;
        v = 0; c = 0; ac = 0; we = 1; r = '0;
        if (sh) begin
            if (!dir) begin r = {a[6:0], 1'b0}; c = a[7]; end
            else      begin r = {1'b0, a[7:1]}; c = a[0]; end
        end else begin
            case (f)
                3'd0: begin r = 8'h00; we = 0; end
                3'd7: begin r = 8'hFF; we = 0; end
                3'd4: r = a ^ b;
                3'd5: r = a | b;
                3'd6: r = a & b;
                3'd3: begin
                    k = (cm == 2'd3 && ci) ? 1 : 0;
                    full = int'(a) + int'(b) + k;
                    nib  = int'(a & 8'h0F) + int'(b & 8'h0F) + k;
                    sv   = sx(a) + sx(b) + k;
                    r = full[7:0]; c = full > 255; ac = nib > 15;
                    v = (sv > 127) || (sv < -128);
                end
                default: begin
                    x = (f == 3'd2) ? a : b;
                    y = (f == 3'd2) ? b : a;
                    k = (f == 3'd2 && cm == 2'd3 && ci) ? 1 : 0;
                    full = int'(x) - int'(y) - k;
                    nib  = int'(x & 8'h0F) - int'(y & 8'h0F) - k;
                    sv   = sx(x) - sx(y) - k;
                    r = full[7:0]; c = full < 0; ac = nib < 0;
                    v = (sv > 127) || (sv < -128);
                end
            endcase
        end
        e.tag = tag;
        e.res = r;
        e.fl  = {r[7], r == 8'h00, v, c, ac, we, cmp};
        return e;
    endfunction

    // Driver: apply one operation after a rising edge and queue its expectation.
    task automatic apply(input string tag, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] f, input logic [1:0] cm, input logic sh,
                         input logic dir, input logic ci, input logic cmp);
        @(posedge clk);
        #1;
        opnd_a = a; opnd_b = b; func_sel = f; carry_mode = cm;
        shift_en = sh; shift_right = dir; carry_in = ci; cmp_req = cmp;
        q.push_back(model(tag, a, b, f, cm, sh, dir, ci, cmp));
    endtask

    // Monitor: results are due in the same cycle; compare at the falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [6:0] got;
            e = q.pop_front();
            got = {flag_sign, flag_zero, flag_ovf, flag_carry, flag_aux, flag_we, result_discard};
            n_checks++;
            if (result !== e.res || got !== e.fl) begin
                n_fail++;
                $display("FAIL %s: result=%h flags(s,z,v,c,ac,we,disc)=%b expected result=%h flags=%b",
                         e.tag, result, got, e.res, e.fl);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero inputs select constant 0x00.
        apply("R6_R8 idle zero", 8'h00, 8'h00, 3'd0, 2'd0, 0, 0, 0, 0);
        // R1 logic and constants
        apply("R1 xor",  8'hF0, 8'hFF, 3'd4, 2'd3, 0, 0, 1, 0);
        apply("R1 or",   8'h81, 8'h02, 3'd5, 2'd0, 0, 0, 1, 0);
        apply("R1 and",  8'h0F, 8'hF0, 3'd6, 2'd0, 0, 0, 0, 0);
        apply("R1_R8 ones", 8'h12, 8'h34, 3'd7, 2'd3, 0, 0, 1, 0);
        apply("R1_R8 zero const", 8'hAB, 8'hCD, 3'd0, 2'd3, 0, 0, 1, 0);
        // R2 addition
        apply("R2 add plain", 8'h12, 8'h34, 3'd3, 2'd0, 0, 0, 0, 0);
        apply("R2 add overflow", 8'h7F, 8'h01, 3'd3, 2'd0, 0, 0, 0, 0);
        apply("R2 add carry wrap", 8'hFF, 8'h01, 3'd3, 2'd0, 0, 0, 0, 0);
        apply("R2 add neg overflow", 8'h80, 8'h80, 3'd3, 2'd2, 0, 0, 1, 0);
        apply("R2 add ignores cin mode1", 8'h0F, 8'h01, 3'd3, 2'd1, 0, 0, 1, 0);
        // R3 add with carry
        apply("R3 adc wrap", 8'hFF, 8'h00, 3'd3, 2'd3, 0, 0, 1, 0);
        apply("R3 adc aux", 8'h08, 8'h07, 3'd3, 2'd3, 0, 0, 1, 0);
        apply("R3 adc cin0", 8'h08, 8'h07, 3'd3, 2'd3, 0, 0, 0, 0);
        // R4 subtraction both orders
        apply("R4 a-b", 8'h05, 8'h03, 3'd2, 2'd0, 0, 0, 0, 0);
        apply("R4 a-b borrow", 8'h03, 8'h05, 3'd2, 2'd0, 0, 0, 0, 0);
        apply("R4 a-b overflow", 8'h80, 8'h01, 3'd2, 2'd0, 0, 0, 0, 0);
        apply("R4 b-a", 8'h03, 8'h05, 3'd1, 2'd0, 0, 0, 0, 0);
        apply("R4 b-a ignores cin mode3", 8'h10, 8'h30, 3'd1, 2'd3, 0, 0, 1, 0);
        apply("R4 a-b ignores cin mode2", 8'h10, 8'h10, 3'd2, 2'd2, 0, 0, 1, 0);
        // R5 subtract with borrow
        apply("R5 sbb aux borrow", 8'h10, 8'h00, 3'd2, 2'd3, 0, 0, 1, 0);
        apply("R5 sbb to zero", 8'h05, 8'h04, 3'd2, 2'd3, 0, 0, 1, 0);
        apply("R5 sbb wrap", 8'h00, 8'h00, 3'd2, 2'd3, 0, 0, 1, 0);
        // R7 shifts
        apply("R7 shl", 8'h81, 8'h00, 3'd3, 2'd0, 1, 0, 0, 0);
        apply("R7 shr", 8'h81, 8'h00, 3'd0, 2'd0, 1, 1, 0, 0);
        apply("R7 shl overrides const", 8'h40, 8'hFF, 3'd7, 2'd3, 1, 0, 1, 0);
        apply("R7 shr to zero", 8'h01, 8'h55, 3'd2, 2'd3, 1, 1, 1, 0);
        // R9 compare
        apply("R9 cmp sub", 8'h03, 8'h05, 3'd2, 2'd0, 0, 0, 0, 1);
        apply("R9 cmp equal", 8'h42, 8'h42, 3'd2, 2'd0, 0, 0, 0, 1);
        apply("R9 cmp add", 8'h7F, 8'h01, 3'd3, 2'd0, 0, 0, 0, 1);
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule